// File: doc/BRIEF.md
# Event-Flag Parallel Port

A small register file on an 8-bit CPU bus with a 4-bit address. It holds two 8-bit output latches, port B and port A. Port A has a per-pin direction register. The block also holds a single interrupt source, driven by an active-low event line, with a flag register and an enable register and an active-low interrupt request output.

Software typically sets port A direction so that the low pins drive a selector and the top pin senses an external state. It then writes a selector value and reads back the sensed pin, or polls the event flag with the enable off so that no interrupt is taken. Once the enable bit is set, the same flag raises the interrupt request.

The event line is asynchronous. It passes through a synchroniser, and only a high-to-low transition sets the flag. A line held low therefore does not set the flag again after software clears it.

Top module: `pio_irq_port`

## Requirements
- R1: After reset, both output latches and the direction register are 0, the flag and the enable are 0, `irq_no` is high, and a read of offset 0xE returns 0x80.
- R2: A write to offset 0x0 loads `pb_o`, and a read of offset 0x0 returns that latch.
- R3: A write to offset 0x3 loads the direction register, which drives `pa_oe_o` and reads back at 0x3. A bit of 1 makes that pin an output, so writing 0x7F makes pins 0–6 outputs and pin 7 an input.
- R4: A write to offset 0xF loads the port A latch shown on `pa_o`. A read of 0xF returns, for each pin, the latch bit where the direction bit is 1 and `pa_i` where it is 0.
- R5: A high-to-low transition of `evt_ni`, seen after SYNC_STAGES synchronising flops, sets the flag at bit 0 of offset 0xD on rising edge SYNC_STAGES+1 after the low level is first sampled. Holding the line low does not set the flag again.
- R6: The flag sets whether or not the enable is set. While the enable is clear, `irq_no` stays high.
- R7: Writing offset 0xD with bit 0 at 1 clears the flag, and writing bit 0 at 0 leaves it alone. A new edge in the same cycle as a clear leaves the flag set.
- R8: A write to offset 0xE with bit 0 at 1 copies bit 7 of the data into the enable, so 1 sets it and 0 clears it. With bit 0 at 0, the enable is unchanged. The enable reads back at bit 0 of 0xE.
- R9: `irq_no` is low exactly while both the flag and the enable are 1.
- R10: Bit 7 of a 0xD read is the flag ANDed with the enable. Bit 7 of a 0xE read is always 1. Bits 1–6 of both read as 0.
- R11: `rdata_o` is 0 while `rd_i` is low. Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, 0 when no read |
| irq_no | output | 1 | Interrupt request, active low |
| pa_i | input | DATA_W | Port A external pin levels |
| pa_o | output | DATA_W | Port A output latch |
| pa_oe_o | output | DATA_W | Port A per-pin output enable |
| pb_o | output | DATA_W | Port B output latch |
| evt_ni | input | 1 | Asynchronous event line, falling edge active |

## Verification
The bench builds the block with DATA_W at 8 and SYNC_STAGES at 3. The deeper synchroniser moves the flag-set edge away from the default timing, so a model that assumed fixed latency would go wrong. It also lets a clear write be placed on exactly the edge where a new event lands, which tests the set-over-clear rule. With an 8-bit width, the per-pin read mix of port A can be tested with the split 0x7F direction and with the top pin both high and low.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_PB     = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_PA_DIR = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_ENA    = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_PA     = 4'hF;
  localparam int unsigned SRC_BIT = 0;
  localparam int unsigned SUM_BIT = 7;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_ni,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES;

  // [STAGES-1] is the synchronised level, [STAGES] its previous value
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[LAST-1:0], line_ni};
  end

  assign fall_o = sh_q[LAST] & ~sh_q[LAST-1];
endmodule

// File: rtl/pio_irq_regs.sv
module pio_irq_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_flag_i,
  input  logic              sel_ena_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fall_i,
  output logic              flag_o,
  output logic              ena_o
);
  import pio_pkg::*;

  logic flag_q, ena_q, clr;

  assign clr = wr_i & sel_flag_i & wdata_i[SRC_BIT];

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= fall_i | (flag_q & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ena_q <= 1'b0;
    else if (wr_i && sel_ena_i && wdata_i[SRC_BIT]) ena_q <= wdata_i[SUM_BIT];
  end

  assign flag_o = flag_q;
  assign ena_o  = ena_q;
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_pb_i,
  input  logic              sel_dir_i,
  input  logic              sel_pa_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pa_i,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] pa_rd_o
);
  logic [DATA_W-1:0] pb_q, pa_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_q  <= '0;
      pa_q  <= '0;
      dir_q <= '0;
    end else if (wr_i) begin
      if (sel_pb_i)  pb_q  <= wdata_i;
      if (sel_pa_i)  pa_q  <= wdata_i;
      if (sel_dir_i) dir_q <= wdata_i;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_pin
    assign pa_rd_o[b] = dir_q[b] ? pa_q[b] : pa_i[b];
  end

  assign pb_o  = pb_q;
  assign pa_o  = pa_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/pio_irq_port.sv
module pio_irq_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [pio_pkg::ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       irq_no,
  input  logic [DATA_W-1:0]          pa_i,
  output logic [DATA_W-1:0]          pa_o,
  output logic [DATA_W-1:0]          pa_oe_o,
  output logic [DATA_W-1:0]          pb_o,
  input  logic                       evt_ni
);
  import pio_pkg::*;

  logic sel_pb, sel_dir, sel_flag, sel_ena, sel_pa;
  logic evt_fall, flag_q, ena_q, pend;
  logic [DATA_W-1:0] dir_w, pa_rd, pb_w, pa_w, rd_mux;

  assign sel_pb   = (addr_i == OFS_PB);
  assign sel_dir  = (addr_i == OFS_PA_DIR);
  assign sel_flag = (addr_i == OFS_FLAG);
  assign sel_ena  = (addr_i == OFS_ENA);
  assign sel_pa   = (addr_i == OFS_PA);

  pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_ni (evt_ni),
    .fall_o  (evt_fall)
  );

  pio_irq_regs #(.DATA_W(DATA_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .sel_flag_i (sel_flag),
    .sel_ena_i  (sel_ena),
    .wdata_i    (wdata_i),
    .fall_i     (evt_fall),
    .flag_o     (flag_q),
    .ena_o      (ena_q)
  );

  pio_port_regs #(.DATA_W(DATA_W)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .sel_pb_i  (sel_pb),
    .sel_dir_i (sel_dir),
    .sel_pa_i  (sel_pa),
    .wdata_i   (wdata_i),
    .pa_i      (pa_i),
    .pb_o      (pb_w),
    .pa_o      (pa_w),
    .dir_o     (dir_w),
    .pa_rd_o   (pa_rd)
  );

  assign pend = flag_q & ena_q;

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_pb:  rd_mux = pb_w;
      sel_dir: rd_mux = dir_w;
      sel_pa:  rd_mux = pa_rd;
      sel_flag: begin
        rd_mux[SRC_BIT] = flag_q;
        rd_mux[SUM_BIT] = pend;
      end
      sel_ena: begin
        rd_mux[SRC_BIT] = ena_q;
        rd_mux[SUM_BIT] = 1'b1;
      end
      default: rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_i ? rd_mux : '0;
  assign irq_no  = ~pend;
  assign pa_o    = pa_w;
  assign pa_oe_o = dir_w;
  assign pb_o    = pb_w;
endmodule

// File: rtl/pio_irq_port_chk.sv
module pio_irq_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_no,
  input logic [DATA_W-1:0] pb_o,
  input logic [DATA_W-1:0] pa_oe_o,
  input logic              flag_i,
  input logic              ena_i,
  input logic              fall_i
);
  a_r2_pb_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h0) |=> pb_o == $past(wdata_i));

  a_r3_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h3) |=> pa_oe_o == $past(wdata_i));

  a_r5_flag_from_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(fall_i));

  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_i |-> irq_no);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'hD && wdata_i[0] && !fall_i) |=> !flag_i);

  a_r8_ena_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'hE && wdata_i[0] && wdata_i[7]) |=> ena_i);

  a_r8_ena_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'hE && wdata_i[0] && !wdata_i[7]) |=> !ena_i);

  a_r9_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (flag_i && ena_i));

  a_r10_ena_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'hE) |-> rdata_o[7]);

  a_r11_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

bind pio_irq_port pio_irq_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .pb_o    (pb_o),
  .pa_oe_o (pa_oe_o),
  .flag_i  (flag_q),
  .ena_i   (ena_q),
  .fall_i  (evt_fall)
);

// File: tb/pio_irq_port_tb_top.sv
`timescale 1ns/1ps
module pio_irq_port_tb_top;
  localparam int S = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata, pa_in = '0, pa_out, pa_oe, pb_out;
  logic       irq_n, evt_n = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pio_irq_port #(.DATA_W(8), .SYNC_STAGES(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_no(irq_n),
    .pa_i(pa_in), .pa_o(pa_out), .pa_oe_o(pa_oe), .pb_o(pb_out),
    .evt_ni(evt_n)
  );

  // reference model
  logic [7:0] m_pb, m_pa, m_dir;
  bit         m_flag, m_ena;
  bit         hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pb = 0; m_pa = 0; m_dir = 0; m_flag = 0; m_ena = 0;
      hist = {};
      for (int i = 0; i <= S; i++) hist.push_back(1'b1);
    end else begin
      bit fall;
      fall = hist[S] && !hist[S-1];
      if (wr) begin
        if (addr == 4'h0) m_pb = wdata;
        if (addr == 4'h3) m_dir = wdata;
        if (addr == 4'hF) m_pa = wdata;
        if (addr == 4'hE && wdata[0]) m_ena = wdata[7];
      end
      if (fall) m_flag = 1;
      else if (wr && addr == 4'hD && wdata[0]) m_flag = 0;
      hist.push_front(evt_n);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd();
    logic [7:0] v = 0;
    if (!rd) return 0;
    case (addr)
      4'h0: v = m_pb;
      4'h3: v = m_dir;
      4'hF: v = (m_dir & m_pa) | (~m_dir & pa_in);
      4'hD: v = {m_flag && m_ena, 6'b0, m_flag};
      4'hE: v = {1'b1, 6'b0, m_ena};
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string rd_tag();
    case (addr)
      4'h0: return "R2";
      4'h3: return "R3";
      4'hF: return "R4";
      4'hD: return "R5";
      4'hE: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    chk("R9", "irq_no", {7'b0, irq_n}, {7'b0, !(m_flag && m_ena)});
    chk("R2", "pb_o", pb_out, m_pb);
    chk("R3", "pa_oe_o", pa_oe, m_dir);
    chk("R4", "pa_o", pa_out, m_pa);
    chk(rd_tag(), "rdata_o", rdata, exp_rd());
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    cyc(); addr = a; wdata = d; wr = 1'b1;
    cyc(); wr = 1'b0;
  endtask

  task automatic expect_rd(logic [3:0] a, logic [7:0] e, string tag);
    cyc(); addr = a; rd = 1'b1;
    @(negedge clk); chk(tag, "read", rdata, e);
    cyc(); rd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(4'hE, 8'h80, "R1");
    expect_rd(4'hD, 8'h00, "R1");
    chk("R1", "irq_no reset", {7'b0, irq_n}, 8'h01);
    // R2
    bus_wr(4'h0, 8'hA5); expect_rd(4'h0, 8'hA5, "R2");
    bus_wr(4'h0, 8'h3C); expect_rd(4'h0, 8'h3C, "R2");
    // R3 / R4
    bus_wr(4'h3, 8'h7F);
    chk("R3", "oe after 0x7F", pa_oe, 8'h7F);
    bus_wr(4'hF, 8'h2A);
    pa_in = 8'h80; expect_rd(4'hF, 8'hAA, "R4");
    pa_in = 8'h00; expect_rd(4'hF, 8'h2A, "R4");
    chk("R4", "pa_o", pa_out, 8'h2A);
    // R6 flag sets with enable off
    evt_n = 1'b0; repeat (S + 2) cyc();
    expect_rd(4'hD, 8'h01, "R6");
    chk("R6", "irq_no with enable off", {7'b0, irq_n}, 8'h01);
    // R5 held low does not re-set; R7 clear
    bus_wr(4'hD, 8'h01); repeat (S + 2) cyc();
    expect_rd(4'hD, 8'h00, "R5");
    evt_n = 1'b1; repeat (S + 2) cyc();
    evt_n = 1'b0; repeat (S + 2) cyc();
    expect_rd(4'hD, 8'h01, "R5");
    // R8 / R9 / R10
    bus_wr(4'hE, 8'h81); expect_rd(4'hE, 8'h81, "R8");
    chk("R9", "irq asserted", {7'b0, irq_n}, 8'h00);
    expect_rd(4'hD, 8'h81, "R10");
    bus_wr(4'hE, 8'h00); expect_rd(4'hE, 8'h81, "R8");
    bus_wr(4'hE, 8'h01); expect_rd(4'hE, 8'h80, "R8");
    chk("R9", "irq released", {7'b0, irq_n}, 8'h01);
    // R7 zero write keeps flag, one write clears
    bus_wr(4'hD, 8'h00); expect_rd(4'hD, 8'h01, "R7");
    bus_wr(4'hD, 8'h01); expect_rd(4'hD, 8'h00, "R7");
    // R11 unmapped offset
    bus_wr(4'h5, 8'hFF); expect_rd(4'h5, 8'h00, "R11");
    expect_rd(4'h0, 8'h3C, "R11");
    // R7 set beats clear on the same edge
    evt_n = 1'b1; repeat (S + 2) cyc();
    evt_n = 1'b0;
    repeat (S) cyc();
    addr = 4'hD; wdata = 8'h01; wr = 1'b1;
    cyc(); wr = 1'b0;
    expect_rd(4'hD, 8'h01, "R7");
    // mixed traffic, model compared every cycle
    for (int i = 0; i < 400; i++) begin
      cyc();
      addr  = 4'($urandom_range(0, 15));
      wdata = 8'($urandom);
      wr    = ($urandom_range(0, 3) == 0);
      rd    = !wr && ($urandom_range(0, 1) == 1);
      pa_in = 8'($urandom);
      if ($urandom_range(0, 7) == 0) evt_n = ~evt_n;
    end
    cyc(); wr = 1'b0; rd = 1'b0;
    repeat (4) cyc();
    summary();
  end
endmodule